// File: doc/BRIEF.md
# Keyboard and Floppy Port Glue

This block sits between a CPU and the three ports of a parallel interface chip on a small computer. A write to the control port latches a keyboard row number, two drive-select requests, a serial connector select and the printer strobe. A separate latch holds the memory bank number written to the low half of the third port. The key-column port returns the 8-bit active-low state of whichever matrix row is latched. The status port gathers printer busy, carrier detect, motor feedback and the write-protect state of the drive that is currently selected.

The block also handles the floppy controller's request lines. The controller's interrupt request passes straight through to the CPU's maskable interrupt. Its data request becomes a non-maskable interrupt, but only while the CPU is halted. This lets a halted CPU wake up for each byte. The key matrix, the drives and the controller itself are outside the block.

Top module: `kbfd_port_glue`

## Requirements
- R1: A write on the control port latches bits 3:0 as the keyboard row number. The row number appears on `row_sel_o` in the cycle after the write edge.
- R2: `col_data_o` shows the 8 bits of the latched row, taken from `key_rows_i[row*8 +: 8]` for rows 0 to 9. Any row number of 10 or above reads 8'hFF.
- R3: Control bit 4 requests drive 0 and control bit 5 requests drive 1. `drv_sel_o` is one-hot or zero. When both bits are set, drive 1 is selected alone (2'b10). When neither is set, the result is 2'b00.
- R4: Control bit 7 is latched onto `prn_strobe_o` and control bit 6 onto `ser_sel_o`.
- R5: The `status_o` bits are as follows:
  - bit 4 is `prn_busy_i`
  - bit 5 is the inverse of `motor_on_i`
  - bit 6 is `carrier_i`
  - bit 7 is the `wp_i` bit of the selected drive, or 0 when no drive is selected
  - bits 3:0 read 0
- R6: `motor_on_i` is forwarded on `drv_motor_o` only to the selected drive. An unselected drive sees 0.
- R7: A write on the bank port latches bits 2:0 onto `bank_o`. Higher data bits are ignored, and control-port writes leave the bank unchanged.
- R8: When DRQ is high and the CPU is halted at a clock edge, `nmi_o` is high after that edge. When DRQ is low at an edge, `nmi_o` is low after it.
- R9: DRQ arriving while the CPU is not halted does not raise `nmi_o`. If the CPU then halts while DRQ stays high, `nmi_o` rises in the cycle after the halt is seen.
- R10: `irq_o` follows `fdc_intrq_i` with no clock delay.
- R11: After reset, the following values hold:
  - row 0
  - no drive selected
  - strobe and serial select low
  - bank 7
  - `nmi_o` low

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| pa_wr_i | input | 1 | Control port write strobe |
| pa_data_i | input | 8 | Control port write data |
| pc_wr_i | input | 1 | Bank port write strobe |
| pc_data_i | input | 8 | Bank port write data |
| key_rows_i | input | 80 | Key matrix, row r in bits r*8+7..r*8, active low |
| row_sel_o | output | 4 | Latched keyboard row |
| col_data_o | output | 8 | Column state of the latched row |
| drv_sel_o | output | 2 | Drive select, bit i = drive i |
| drv_motor_o | output | 2 | Motor-on forwarded to the selected drive |
| motor_on_i | input | 1 | Motor-on level from the timer |
| wp_i | input | 2 | Write-protect of each drive |
| prn_busy_i | input | 1 | Printer busy |
| carrier_i | input | 1 | Serial carrier detect |
| prn_strobe_o | output | 1 | Printer strobe |
| ser_sel_o | output | 1 | Serial connector select |
| status_o | output | 8 | Status byte |
| bank_o | output | 3 | Latched memory bank number |
| fdc_drq_i | input | 1 | Controller data request |
| fdc_intrq_i | input | 1 | Controller interrupt request |
| cpu_halt_i | input | 1 | CPU halted |
| nmi_o | output | 1 | Non-maskable interrupt to CPU |
| irq_o | output | 1 | Maskable interrupt to CPU |

## Verification
Two functions can act in the same clock edge: a control-port write that moves the drive select, and a data request that meets a halted CPU. The bench provokes this by asserting DRQ and halt in the same cycle as a write that switches from drive 0 to drive 1. In the following cycle it checks three results together: `nmi_o` is high, `drv_sel_o` is 2'b10, and status bit 7 follows the write-protect input of drive 1 rather than drive 0.

// File: rtl/kbfd_pkg.sv
package kbfd_pkg;
  localparam int BYTE_W   = 8;
  localparam int ROW_W    = 4;
  localparam int DRV_N    = 2;
  localparam int DRV_LSB  = ROW_W;
  localparam int SER_BIT  = 6;
  localparam int STB_BIT  = 7;
  localparam int ST_BUSY  = 4;
  localparam int ST_MFB   = 5;
  localparam int ST_CD    = 6;
  localparam int ST_WP    = 7;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic             strobe;
    logic             ser_sel;
    logic [DRV_N-1:0] drv_req;
    logic [ROW_W-1:0] row;
  } ctl_t;
endpackage

// File: rtl/kbfd_rst_sync.sv
module kbfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/kbfd_ctl_reg.sv
module kbfd_ctl_reg
  import kbfd_pkg::*;
#(
  parameter int BANK_W   = 3,
  parameter int RST_BANK = 7
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              pa_wr_i,
  input  byte_t             pa_data_i,
  input  logic              pc_wr_i,
  input  byte_t             pc_data_i,
  output ctl_t              ctl_o,
  output logic [BANK_W-1:0] bank_o
);
  ctl_t              ctl_q, ctl_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic              unused_pc_hi;

  assign unused_pc_hi = ^pc_data_i[BYTE_W-1:BANK_W];

  always_comb begin
    ctl_d = ctl_q;
    if (pa_wr_i) begin
      ctl_d.row     = pa_data_i[ROW_W-1:0];
      ctl_d.drv_req = pa_data_i[DRV_LSB +: DRV_N];
      ctl_d.ser_sel = pa_data_i[SER_BIT];
      ctl_d.strobe  = pa_data_i[STB_BIT];
    end
  end

  always_comb begin
    bank_d = bank_q;
    if (pc_wr_i) bank_d = pc_data_i[BANK_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctl_q  <= '0;
      bank_q <= BANK_W'(RST_BANK);
    end else begin
      ctl_q  <= ctl_d;
      bank_q <= bank_d;
    end
  end

  assign ctl_o  = ctl_q;
  assign bank_o = bank_q;
endmodule

// File: rtl/kbfd_key_mux.sv
module kbfd_key_mux
  import kbfd_pkg::*;
#(
  parameter int ROWS = 10,
  parameter int COLS = 8
) (
  input  logic [ROWS*COLS-1:0] key_rows_i,
  input  logic [ROW_W-1:0]     row_i,
  output logic [COLS-1:0]      col_o
);
  localparam int SLOTS = 1 << ROW_W;

  logic [COLS-1:0] slot [SLOTS];

  for (genvar r = 0; r < SLOTS; r++) begin : g_slot
    if (r < ROWS) begin : g_row
      assign slot[r] = key_rows_i[r*COLS +: COLS];
    end else begin : g_empty
      assign slot[r] = '1;
    end
  end

  assign col_o = slot[row_i];
endmodule

// File: rtl/kbfd_drive_sel.sv
module kbfd_drive_sel
  import kbfd_pkg::*;
(
  input  logic [DRV_N-1:0] req_i,
  input  logic             motor_on_i,
  input  logic [DRV_N-1:0] wp_i,
  output logic [DRV_N-1:0] sel_o,
  output logic [DRV_N-1:0] motor_o,
  output logic             wp_sel_o
);
  always_comb begin
    sel_o = '0;
    for (int i = 0; i < DRV_N; i++) begin
      if (req_i[i]) begin
        sel_o    = '0;
        sel_o[i] = 1'b1;
      end
    end
  end

  assign motor_o  = sel_o & {DRV_N{motor_on_i}};
  assign wp_sel_o = |(sel_o & wp_i);
endmodule

// File: rtl/kbfd_nmi_gen.sv
module kbfd_nmi_gen (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic drq_i,
  input  logic halt_i,
  output logic nmi_o
);
  logic nmi_q, nmi_d;

  always_comb begin
    nmi_d = nmi_q;
    if (!drq_i)      nmi_d = 1'b0;
    else if (halt_i) nmi_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) nmi_q <= 1'b0;
    else          nmi_q <= nmi_d;
  end

  assign nmi_o = nmi_q;
endmodule

// File: rtl/kbfd_port_glue.sv
module kbfd_port_glue
  import kbfd_pkg::*;
#(
  parameter int ROWS     = 10,
  parameter int COLS     = 8,
  parameter int BANK_W   = 3,
  parameter int RST_BANK = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 pa_wr_i,
  input  logic [7:0]           pa_data_i,
  input  logic                 pc_wr_i,
  input  logic [7:0]           pc_data_i,
  input  logic [ROWS*COLS-1:0] key_rows_i,
  output logic [ROW_W-1:0]     row_sel_o,
  output logic [COLS-1:0]      col_data_o,
  output logic [DRV_N-1:0]     drv_sel_o,
  output logic [DRV_N-1:0]     drv_motor_o,
  input  logic                 motor_on_i,
  input  logic [DRV_N-1:0]     wp_i,
  input  logic                 prn_busy_i,
  input  logic                 carrier_i,
  output logic                 prn_strobe_o,
  output logic                 ser_sel_o,
  output logic [7:0]           status_o,
  output logic [BANK_W-1:0]    bank_o,
  input  logic                 fdc_drq_i,
  input  logic                 fdc_intrq_i,
  input  logic                 cpu_halt_i,
  output logic                 nmi_o,
  output logic                 irq_o
);
  logic rst_n_q;
  ctl_t ctl;
  logic wp_sel;

  kbfd_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_q)
  );

  kbfd_ctl_reg #(.BANK_W(BANK_W), .RST_BANK(RST_BANK)) u_ctl (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_q),
    .pa_wr_i   (pa_wr_i),
    .pa_data_i (pa_data_i),
    .pc_wr_i   (pc_wr_i),
    .pc_data_i (pc_data_i),
    .ctl_o     (ctl),
    .bank_o    (bank_o)
  );

  kbfd_key_mux #(.ROWS(ROWS), .COLS(COLS)) u_keys (
    .key_rows_i (key_rows_i),
    .row_i      (ctl.row),
    .col_o      (col_data_o)
  );

  kbfd_drive_sel u_drv (
    .req_i      (ctl.drv_req),
    .motor_on_i (motor_on_i),
    .wp_i       (wp_i),
    .sel_o      (drv_sel_o),
    .motor_o    (drv_motor_o),
    .wp_sel_o   (wp_sel)
  );

  kbfd_nmi_gen u_nmi (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_q),
    .drq_i   (fdc_drq_i),
    .halt_i  (cpu_halt_i),
    .nmi_o   (nmi_o)
  );

  always_comb begin
    status_o          = '0;
    status_o[ST_BUSY] = prn_busy_i;
    status_o[ST_MFB]  = ~motor_on_i;
    status_o[ST_CD]   = carrier_i;
    status_o[ST_WP]   = wp_sel;
  end

  assign row_sel_o    = ctl.row;
  assign prn_strobe_o = ctl.strobe;
  assign ser_sel_o    = ctl.ser_sel;
  assign irq_o        = fdc_intrq_i;
endmodule

// File: rtl/kbfd_port_glue_chk.sv
module kbfd_port_glue_chk (
  input logic       clk_i,
  input logic       rst_n_q,
  input logic       pa_wr_i,
  input logic [7:0] pa_data_i,
  input logic       pc_wr_i,
  input logic [2:0] bank_o,
  input logic [1:0] drv_sel_o,
  input logic [1:0] drv_motor_o,
  input logic       motor_on_i,
  input logic [7:0] status_o,
  input logic       fdc_drq_i,
  input logic       fdc_intrq_i,
  input logic       cpu_halt_i,
  input logic       nmi_o,
  input logic       irq_o
);
  p_drv_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    $onehot0(drv_sel_o));

  p_drv_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (pa_wr_i && pa_data_i[5]) |=> (drv_sel_o == 2'b10));

  p_status_low_r5: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (status_o[3:0] == 4'h0) && (status_o[5] != motor_on_i));

  p_motor_unsel_r6: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (drv_motor_o & ~drv_sel_o) == 2'b00);

  p_bank_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    !pc_wr_i |=> $stable(bank_o));

  p_nmi_set_r8: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (fdc_drq_i && cpu_halt_i) |=> nmi_o);

  p_nmi_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    !fdc_drq_i |=> !nmi_o);

  p_nmi_nohalt_r9: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (!nmi_o && !cpu_halt_i) |=> !nmi_o);

  p_irq_pass_r10: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    irq_o == fdc_intrq_i);
endmodule

bind kbfd_port_glue kbfd_port_glue_chk u_chk (
  .clk_i       (clk_i),
  .rst_n_q     (rst_n_q),
  .pa_wr_i     (pa_wr_i),
  .pa_data_i   (pa_data_i),
  .pc_wr_i     (pc_wr_i),
  .bank_o      (bank_o),
  .drv_sel_o   (drv_sel_o),
  .drv_motor_o (drv_motor_o),
  .motor_on_i  (motor_on_i),
  .status_o    (status_o),
  .fdc_drq_i   (fdc_drq_i),
  .fdc_intrq_i (fdc_intrq_i),
  .cpu_halt_i  (cpu_halt_i),
  .nmi_o       (nmi_o),
  .irq_o       (irq_o)
);

// File: tb/kbfd_port_glue_tb.sv
`timescale 1ns/1ps
module kbfd_port_glue_tb_top;
  localparam real TCK = 4.0;
  localparam int  NV  = 8;
  // {pa byte, expected drv_sel, expected column, expected strobe, expected serial}
  localparam logic [19:0] VEC [NV] = '{
    {8'h00, 2'b00, 8'h30, 1'b0, 1'b0},
    {8'h13, 2'b01, 8'h33, 1'b0, 1'b0},
    {8'h29, 2'b10, 8'h39, 1'b0, 1'b0},
    {8'h35, 2'b10, 8'h35, 1'b0, 1'b0},
    {8'h0A, 2'b00, 8'hFF, 1'b0, 1'b0},
    {8'h8F, 2'b00, 8'hFF, 1'b1, 1'b0},
    {8'h47, 2'b00, 8'h37, 1'b0, 1'b1},
    {8'hD2, 2'b01, 8'h32, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pa_wr, pc_wr;
  logic [7:0]  pa_data, pc_data;
  logic [79:0] keys;
  logic [3:0]  row_sel;
  logic [7:0]  col, status;
  logic [1:0]  drv_sel, drv_motor, wp;
  logic        motor_on, busy, carrier, strobe, ser_sel;
  logic [2:0]  bank;
  logic        drq, intrq, halt, nmi, irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(TCK/2) clk = ~clk;

  kbfd_port_glue dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .pa_wr_i(pa_wr), .pa_data_i(pa_data),
    .pc_wr_i(pc_wr), .pc_data_i(pc_data), .key_rows_i(keys),
    .row_sel_o(row_sel), .col_data_o(col), .drv_sel_o(drv_sel),
    .drv_motor_o(drv_motor), .motor_on_i(motor_on), .wp_i(wp),
    .prn_busy_i(busy), .carrier_i(carrier), .prn_strobe_o(strobe),
    .ser_sel_o(ser_sel), .status_o(status), .bank_o(bank),
    .fdc_drq_i(drq), .fdc_intrq_i(intrq), .cpu_halt_i(halt),
    .nmi_o(nmi), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_pa(input logic [7:0] b);
    @(negedge clk); pa_wr = 1'b1; pa_data = b;
    @(negedge clk); pa_wr = 1'b0;
  endtask

  task automatic wr_pc(input logic [7:0] b);
    @(negedge clk); pc_wr = 1'b1; pc_data = b;
    @(negedge clk); pc_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 100000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 10; r++) keys[r*8 +: 8] = 8'h30 + 8'(r);
    rst_n = 1'b0; pa_wr = 1'b0; pc_wr = 1'b0; pa_data = '0; pc_data = '0;
    motor_on = 1'b0; wp = 2'b00; busy = 1'b0; carrier = 1'b0;
    drq = 1'b0; intrq = 1'b0; halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    check("R11 row", {4'h0, row_sel}, 8'h00);
    check("R11 drv", {6'h0, drv_sel}, 8'h00);
    check("R11 strobe/ser", {6'h0, strobe, ser_sel}, 8'h00);
    check("R11 bank", {5'h0, bank}, 8'h07);
    check("R11 nmi", {7'h0, nmi}, 8'h00);

    // R1 R2 R3 R4 vector table
    for (int i = 0; i < NV; i++) begin
      wr_pa(VEC[i][19:12]);
      check("R1 row", {4'h0, row_sel}, {4'h0, VEC[i][15:12]});
      check("R2 col", col, VEC[i][9:2]);
      check("R3 drv", {6'h0, drv_sel}, {6'h0, VEC[i][11:10]});
      check("R4 stb/ser", {6'h0, strobe, ser_sel}, {6'h0, VEC[i][1:0]});
    end

    // R5 status: write-protect follows selected drive
    wp = 2'b01; busy = 1'b1; carrier = 1'b0; motor_on = 1'b1;
    wr_pa(8'h10);
    check("R5 status drv0", status, 8'h90);
    wr_pa(8'h20);
    check("R5 status drv1", status, 8'h10);
    wp = 2'b10; busy = 1'b0; carrier = 1'b1; motor_on = 1'b0;
    #1;
    check("R5 status drv1 wp", status, 8'hE0);
    wr_pa(8'h00);
    check("R5 status none", status, 8'h60);

    // R6 motor forwarding
    motor_on = 1'b1;
    wr_pa(8'h20);
    check("R6 motor drv1", {6'h0, drv_motor}, 8'h02);
    wr_pa(8'h10);
    check("R6 motor drv0", {6'h0, drv_motor}, 8'h01);
    wr_pa(8'h00);
    check("R6 motor none", {6'h0, drv_motor}, 8'h00);

    // R7 bank latch, upper bits ignored
    wr_pc(8'hFD);
    check("R7 bank", {5'h0, bank}, 8'h05);
    wr_pa(8'hFF);
    check("R7 bank after pa", {5'h0, bank}, 8'h05);
    wr_pc(8'h0A);
    check("R7 bank 2", {5'h0, bank}, 8'h02);

    // R9 DRQ without halt, then halt arrives
    @(negedge clk); drq = 1'b1; halt = 1'b0;
    @(negedge clk);
    check("R9 no halt", {7'h0, nmi}, 8'h00);
    @(negedge clk);
    check("R9 no halt 2", {7'h0, nmi}, 8'h00);
    halt = 1'b1;
    @(negedge clk);
    check("R9 late halt", {7'h0, nmi}, 8'h01);
    halt = 1'b0;
    @(negedge clk);
    check("R8 hold while drq", {7'h0, nmi}, 8'h01);
    drq = 1'b0;
    @(negedge clk);
    check("R8 clear", {7'h0, nmi}, 8'h00);

    // R10 irq passthrough
    intrq = 1'b1; #1;
    check("R10 irq high", {7'h0, irq}, 8'h01);
    intrq = 1'b0; #1;
    check("R10 irq low", {7'h0, irq}, 8'h00);

    // R8 R3 same-cycle: drive switch and DRQ during halt
    wp = 2'b10; motor_on = 1'b0; busy = 1'b0; carrier = 1'b0;
    wr_pa(8'h10);
    @(negedge clk); pa_wr = 1'b1; pa_data = 8'h20; drq = 1'b1; halt = 1'b1;
    @(negedge clk); pa_wr = 1'b0;
    check("R8 nmi same cycle", {7'h0, nmi}, 8'h01);
    check("R3 drv same cycle", {6'h0, drv_sel}, 8'h02);
    check("R5 wp same cycle", status, 8'hA0);
    drq = 1'b0; halt = 1'b0;
    @(negedge clk);
    check("R8 clear end", {7'h0, nmi}, 8'h00);

    finish_run();
  end
endmodule